// File: doc/BRIEF.md
# Bit-Addressable General-Purpose I/O Port

This block is a 16-pin general-purpose I/O port seen through a small register interface. Its central state is one data register. Software may write that register whole, or alter chosen bits through three alias offsets that set, clear or invert only the bits written as 1. Because of these aliases, changing one pin never needs a read-modify-write sequence. A read of any of the three aliases returns the data register.

Each pin has four configuration bits: direction, function-enable, sensitivity and polarity. A pin drives its output only when it is set as an output and its function-enable bit is 0. Inputs pass through a two-stage synchronizer. A level-sensitive input copies its synchronized level into the data bit on every clock. An edge-sensitive input sets its data bit on the selected edge, and the bit then stays at 1 until software clears it. A single port flag reports any data bit set on an input pin.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low at a clock edge, every register clears. As a result, rdata reads 0 at every offset, pin_oe is 0 and port_flag is 0.
- R2: The register offsets are: data 0, set alias 1, clear alias 2, toggle alias 3, direction 4 (1 = output), function-enable 5, sensitivity 6 (1 = edge), polarity 7 (1 = falling) and pin readback 8. A write to offset 0 replaces every data bit of an output pin on the next edge.
- R3: A write to offset 1 sets each data bit written as 1. Bits written as 0 keep their value.
- R4: A write to offset 2 clears each data bit written as 1. Bits written as 0 keep their value. For example, writing 0x0030 clears bits 4 and 5 only.
- R5: A write to offset 3 inverts each data bit written as 1. Bits written as 0 keep their value.
- R6: A read of offset 1, 2 or 3 returns the current data register.
- R7: pin_oe for a pin is 1 exactly when its direction bit is 1 and its function-enable bit is 0. pin_out carries the data register.
- R8: On an edge-sensitive input, the selected edge sets the data bit. The bit appears three clock edges after the pin changes. It stays 1 after the pin returns, until a clear write removes it.
- R9: When an edge capture and a set, clear, toggle or data write hit the same bit in the same cycle, the bit ends at 1.
- R10: On a level-sensitive input, the data bit follows the synchronized pin on every clock. Writes to that bit have no effect.
- R11: When a pin's polarity bit is 1, only a falling edge captures. A rising edge leaves the bit at 0.
- R12: port_flag is 1 when any data bit of a pin whose direction bit is 0 is 1.
- R13: A read of offset 8 returns the synchronized pin levels, two clock edges after a pin change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output value per pin |
| pin_oe | output | 16 | Output enable per pin |
| port_flag | output | 1 | Any input-pin data bit set |

## Verification
The bench sets up a clear write that lands in the very cycle an edge is captured. A design that let the write win would lose the event, and the bit would read 0. It checks that an edge-captured bit survives after the pin returns, and that a rising edge is ignored when falling polarity is chosen. A design that tracked the level, or ignored polarity, would show the wrong bit. It also writes all ones to a level-sensitive input to show that the write has no effect. Alias writes of zero, and reads of every alias, catch aliases that modify unselected bits or read back something other than the data register.

// File: rtl/gpio_pkg.sv
// gpio_pkg: register offsets shared by the port, its checker and its bench.
// Assumes a 4-bit offset field on the register interface.
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 4'd0,
        REG_SET   = 4'd1,
        REG_CLR   = 4'd2,
        REG_TGL   = 4'd3,
        REG_DIR   = 4'd4,
        REG_FEN   = 4'd5,
        REG_SENSE = 4'd6,
        REG_POL   = 4'd7,
        REG_PINS  = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
// gpio_cfg_regs: per-pin configuration registers (direction, function-enable,
// sensitivity, polarity). Assumes writes are single-cycle strobes.
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WIDTH-1:0]      wdata,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      fen_q,
    output logic [WIDTH-1:0]      sense_q,
    output logic [WIDTH-1:0]      pol_q
);
    // Load each configuration register when its offset is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            fen_q   <= '0;
            sense_q <= '0;
            pol_q   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                REG_DIR:   dir_q   <= wdata;
                REG_FEN:   fen_q   <= wdata;
                REG_SENSE: sense_q <= wdata;
                REG_POL:   pol_q   <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// gpio_in_sync: a synchronizer chain per pin, plus one history flop.
// Produces the synchronized level and a one-cycle edge pulse. The polarity
// input picks the edge. Assumes SYNC_STAGES >= 2.
module gpio_in_sync #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] pol,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] edge_hit
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] stage_q [SYNC_STAGES];
    logic [WIDTH-1:0] prev_q;

    // First synchronizer stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_in;
    end

    // Remaining synchronizer stages shift the sample along the chain.
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // History flop holds the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[LAST];
    end

    assign level = stage_q[LAST];

    // Per pin: choose a rising or falling transition according to polarity.
    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        always_comb begin
            if (pol[b]) edge_hit[b] = prev_q[b] & ~level[b];
            else        edge_hit[b] = level[b] & ~prev_q[b];
        end
    end
endmodule

// File: rtl/gpio_data_reg.sv
// gpio_data_reg: the port data register with whole, set, clear and toggle
// updates. Level-sensitive inputs track the pin. Edge captures on
// edge-sensitive inputs override any same-cycle write. Assumes at most one
// write strobe is active per cycle.
module gpio_data_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic             wr_tgl,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] sense,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] edge_hit,
    output logic [WIDTH-1:0] data_q
);
    logic [WIDTH-1:0] sw_next;
    logic [WIDTH-1:0] data_d;

    // Software view: the value the write alone would leave in the register.
    always_comb begin
        if (wr_data)     sw_next = wdata;
        else if (wr_set) sw_next = data_q | wdata;
        else if (wr_clr) sw_next = data_q & ~wdata;
        else if (wr_tgl) sw_next = data_q ^ wdata;
        else             sw_next = data_q;
    end

    // Per bit: the pin source (level or capture) takes precedence over software.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            if (!dir[b] && !sense[b])        data_d[b] = level[b];
            else if (!dir[b] && edge_hit[b]) data_d[b] = 1'b1;
            else                             data_d[b] = sw_next[b];
        end
    end

    // Data register update.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end
endmodule

// File: rtl/gpio_port.sv
// gpio_port: 16-pin general-purpose I/O port with bit-addressable data
// updates. The register read is combinational. Pins are asynchronous and are
// synchronized internally.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              port_flag
);
    logic [WIDTH-1:0] dir_q, fen_q, sense_q, pol_q;
    logic [WIDTH-1:0] pin_sync, edge_hit, data_q;
    logic             wr_data, wr_set, wr_clr, wr_tgl;

    // Decode the write strobes that target the data register and its aliases.
    always_comb begin
        wr_data = bus_wr && (bus_addr == REG_DATA);
        wr_set  = bus_wr && (bus_addr == REG_SET);
        wr_clr  = bus_wr && (bus_addr == REG_CLR);
        wr_tgl  = bus_wr && (bus_addr == REG_TGL);
    end

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .fen_q   (fen_q),
        .sense_q (sense_q),
        .pol_q   (pol_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pol      (pol_q),
        .level    (pin_sync),
        .edge_hit (edge_hit)
    );

    gpio_data_reg #(.WIDTH(WIDTH)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr),
        .wr_tgl   (wr_tgl),
        .wdata    (bus_wdata),
        .dir      (dir_q),
        .sense    (sense_q),
        .level    (pin_sync),
        .edge_hit (edge_hit),
        .data_q   (data_q)
    );

    // Read mux: the data register and all three aliases return the same contents.
    always_comb begin
        case (reg_addr_e'(bus_addr))
            REG_DATA, REG_SET, REG_CLR, REG_TGL: bus_rdata = data_q;
            REG_DIR:   bus_rdata = dir_q;
            REG_FEN:   bus_rdata = fen_q;
            REG_SENSE: bus_rdata = sense_q;
            REG_POL:   bus_rdata = pol_q;
            REG_PINS:  bus_rdata = pin_sync;
            default:   bus_rdata = '0;
        endcase
    end

    // Pin drive: output only when the pin is an output and the function-enable bit is clear.
    always_comb begin
        pin_out   = data_q;
        pin_oe    = dir_q & ~fen_q;
        port_flag = |(data_q & ~dir_q);
    end
endmodule

// File: rtl/gpio_port_chk.sv
// gpio_port_chk: temporal checks on the data register, bound into every
// gpio_port instance. Checks only bits whose update source is unambiguous.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  data_q,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  sense_q,
    input logic [WIDTH-1:0]  pin_sync,
    input logic [WIDTH-1:0]  edge_hit
);
    logic touch_edge_bits;
    // A write that could legally lower a captured bit or change its configuration.
    assign touch_edge_bits = bus_wr && (bus_addr == REG_DATA || bus_addr == REG_CLR ||
                                        bus_addr == REG_TGL || bus_addr == REG_DIR ||
                                        bus_addr == REG_SENSE);

    // R2: a whole write lands on every output bit.
    assert_whole_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA) |=>
        (((data_q ^ $past(bus_wdata)) & $past(dir_q)) == '0));

    // R3: set alias raises the selected output bits.
    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_SET) |=>
        ((data_q & $past(bus_wdata & dir_q)) == $past(bus_wdata & dir_q)));

    // R4: clear alias lowers the selected output bits.
    assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_CLR) |=>
        ((data_q & $past(bus_wdata & dir_q)) == '0));

    // R8: captured edge-input bits stay set unless software may clear them.
    assert_sticky_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_edge_bits |=>
        ((data_q & $past(data_q & ~dir_q & sense_q)) == $past(data_q & ~dir_q & sense_q)));

    // R9: an edge on an edge-sensitive input always yields 1, whatever is written.
    assert_capture_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && (bus_addr == REG_DIR || bus_addr == REG_SENSE))) |=>
        ((data_q & $past(edge_hit & ~dir_q & sense_q)) == $past(edge_hit & ~dir_q & sense_q)));

    // R10: level-sensitive inputs copy the synchronized pin.
    assert_level_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && (bus_addr == REG_DIR || bus_addr == REG_SENSE))) |=>
        (((data_q ^ $past(pin_sync)) & $past(~dir_q & ~sense_q)) == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .sense_q   (sense_q),
    .pin_sync  (pin_sync),
    .edge_hit  (edge_hit)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int NV = 8;

    // Vector fields: [35:32] offset, [31:16] write data, [15:0] expected data.
    localparam logic [35:0] VECS [NV] = '{
        {4'd0, 16'hA5A5, 16'hA5A5},
        {4'd1, 16'h0F00, 16'hAFA5},
        {4'd2, 16'h0030, 16'hAF85},
        {4'd3, 16'hFFFF, 16'h507A},
        {4'd1, 16'h0000, 16'h507A},
        {4'd2, 16'h0000, 16'h507A},
        {4'd3, 16'h000F, 16'h5075},
        {4'd0, 16'h0000, 16'h0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic         port_flag;
    int           n_checks = 0;
    int           n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .port_flag (port_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write takes effect at the next posedge.
    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic string op_req(input logic [3:0] a);
        case (a)
            4'd0:    return "R2";
            4'd1:    return "R3";
            4'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
    end

    initial begin
        logic [W-1:0] r;
        // R1: reset state at all offsets
        repeat (3) @(negedge clk);
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), r);
            chk("R1 rdata", r, 0);
        end
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 port_flag", port_flag, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // All outputs, no function enable
        wr(4'd4, 16'hFFFF);
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i][35:32], VECS[i][31:16]);
            rd(4'd0, r);
            chk(op_req(VECS[i][35:32]), r, VECS[i][15:0]);
            rd(4'(1 + (i % 3)), r);
            chk("R6 alias read", r, VECS[i][15:0]);
            chk("R7 pin_out", pin_out, VECS[i][15:0]);
        end

        // R7: output enable from direction and function-enable
        wr(4'd4, 16'h00FF);
        wr(4'd5, 16'h000F);
        chk("R7 pin_oe", pin_oe, 16'h00F0);
        wr(4'd5, 16'h0000);
        chk("R7 pin_oe fen off", pin_oe, 16'h00FF);

        // R10/R13/R12: level-sensitive inputs
        wr(4'd4, 16'h0000);
        wr(4'd6, 16'h0000);
        pin_in = 16'h1234;
        repeat (2) @(negedge clk);
        rd(4'd8, r);
        chk("R13 pin readback", r, 16'h1234);
        @(negedge clk);
        rd(4'd0, r);
        chk("R10 level follows", r, 16'h1234);
        chk("R12 flag set", port_flag, 1);
        wr(4'd0, 16'hFFFF);
        rd(4'd0, r);
        chk("R10 write ignored", r, 16'h1234);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        rd(4'd0, r);
        chk("R10 level low", r, 16'h0000);
        chk("R12 flag clear", port_flag, 0);

        // R8: rising edge capture is sticky
        wr(4'd6, 16'hFFFF);
        pin_in = 16'h0001;
        repeat (3) @(negedge clk);
        rd(4'd0, r);
        chk("R8 capture", r, 16'h0001);
        pin_in = 16'h0000;
        repeat (4) @(negedge clk);
        rd(4'd0, r);
        chk("R8 sticky", r, 16'h0001);
        wr(4'd2, 16'h0001);
        rd(4'd0, r);
        chk("R8 cleared", r, 16'h0000);

        // R11: falling polarity on bit 1
        wr(4'd7, 16'h0002);
        pin_in = 16'h0002;
        repeat (4) @(negedge clk);
        rd(4'd0, r);
        chk("R11 rising ignored", r, 16'h0000);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        rd(4'd0, r);
        chk("R11 falling captured", r, 16'h0002);
        wr(4'd2, 16'h0002);

        // R9: clear write lands in the capture cycle of bit 2
        pin_in = 16'h0004;
        repeat (2) @(negedge clk);
        wr(4'd2, 16'h0004);
        rd(4'd0, r);
        chk("R9 capture wins", r, 16'h0004);
        wr(4'd2, 16'h0004);
        rd(4'd0, r);
        chk("R9 later clear works", r, 16'h0000);

        // R12: outputs never raise the flag
        wr(4'd4, 16'hFFFF);
        wr(4'd0, 16'hFFFF);
        chk("R12 outputs only", port_flag, 0);

        report();
    end
endmodule